// File: doc/BRIEF.md
# Synchronous Parallel Byte Configuration Receiver

This block is a slave that takes configuration data one byte at a time from an 8-bit parallel bus. A free-running configuration clock times the bus, and that clock comes from outside the block. Nothing on the bus tells the block when a byte is present. Once the init-ready input is high, bytes are taken on a fixed schedule of rising clock edges. Each capture raises an acknowledge output for one clock period. That output is informational only, and the schedule never waits for it.

Each captured byte goes to internal logic with a one-cycle valid strobe. The same byte is also re-serialized on a daisy-chain output for a downstream device. Serialization starts on the falling edge half a clock period after the parallel load. It sends the most significant bit first, one bit per clock period, so eight bits fill the gap between two captures exactly.

If init-ready drops, the stream is aborted. The edge count starts again from zero when init-ready rises.

Top module: `pbyte_cfg_rx`

## Requirements
- R1: While reset is asserted (rstN low), ack and byteValid are 0 and serialOut is at the idle level 1.
- R2: The first byte is captured on the second rising edge of clk at which initReady is sampled high. Counting those edges from 1, ack is therefore high in the cycle after edge 2.
- R3: Each later byte is captured exactly 8 rising edges after the previous capture, for as long as initReady stays high. No input throttles this schedule.
- R4: ack is high for exactly one clock period after each capture. byteValid is high in the same cycle, with byteData equal to the captured byte.
- R5: dataIn is sampled only on capture edges. Its value on every other edge has no effect on byteData.
- R6: On the falling edge that follows a capture, serialOut presents bit 7 of the captured byte. Bits 6 down to 0 follow, one per falling edge.
- R7: Shifting goes on while the clock runs. The last byte of a stream is complete on serialOut only after 7 more falling edges past its load.
- R8: While initReady is low, ack and byteValid stay 0. From the next falling edge on, serialOut is held at the idle level 1.
- R9: If initReady falls in the middle of a stream and then rises again, the first capture again falls on the second edge sampled high. No phase is carried over from the aborted stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Externally supplied configuration clock |
| rstN | input | 1 | Asynchronous reset, active low |
| initReady | input | 1 | High once the device may accept data; low aborts the stream |
| dataIn | input | 8 | Parallel configuration byte |
| ack | output | 1 | One-period pulse after each capture |
| serialOut | output | 1 | Daisy-chain serial data, MSB first, changes on falling edges |
| byteValid | output | 1 | One-cycle strobe to internal logic |
| byteData | output | 8 | Most recently captured byte |

## Verification
Inputs change 1 ns after a rising edge, so every input is stable well before both edges of that cycle. ack, byteValid and byteData come from one register stage. Their values are read 1 ns after the rising edge that captured the byte. serialOut comes from a falling-edge register, so it is read 1 ns after each falling edge. The expected bit is the captured byte's bit 7 minus the number of rising edges since the capture. An abort is checked at the falling edge of the same cycle, and a restart is counted again from the first edge sampled high.

// File: rtl/pbyte_cfg_rx_pkg.sv
`timescale 1ns/1ps
package pbyte_cfg_rx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // this rising edge loads the parallel byte
    logic abort;    // initReady low: drop stream state
  } rxStrobe_t;
endpackage

// File: rtl/pbyte_cfg_rx_ctrl.sv
`timescale 1ns/1ps
module pbyte_cfg_rx_ctrl
  import pbyte_cfg_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEAD_EDGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      initReady,
  output rxStrobe_t strobe,
  output logic      ack
);
  localparam int PH_W   = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam int LEAD_W = $clog2(LEAD_EDGES + 1);
  localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(DATA_W - 1);
  localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_EDGES - 1);

  typedef enum logic {ST_LEAD, ST_STREAM} rxState_t;

  rxState_t          state;
  logic [LEAD_W-1:0] leadCnt;
  logic [PH_W-1:0]   phase;
  logic              captureNow;

  always_comb begin
    captureNow = 1'b0;
    if (initReady) begin
      if (state == ST_LEAD) captureNow = (leadCnt == LEAD_LAST);
      else                  captureNow = (phase == PH_LAST);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LEAD;
      leadCnt <= '0;
      phase   <= '0;
      ack     <= 1'b0;
    end else if (!initReady) begin
      state   <= ST_LEAD;
      leadCnt <= '0;
      phase   <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= captureNow;
      if (state == ST_LEAD) begin
        if (captureNow) begin
          state <= ST_STREAM;
          phase <= '0;
        end else begin
          leadCnt <= leadCnt + 1'b1;
        end
      end else begin
        phase <= captureNow ? '0 : phase + 1'b1;
      end
    end
  end

  assign strobe.capture = captureNow;
  assign strobe.abort   = !initReady;
endmodule

// File: rtl/pbyte_cfg_rx_datapath.sv
`timescale 1ns/1ps
module pbyte_cfg_rx_datapath
  import pbyte_cfg_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteValid <= 1'b0;
      byteData  <= '0;
    end else if (strobe.abort) begin
      byteValid <= 1'b0;
    end else begin
      byteValid <= strobe.capture;
      if (strobe.capture) byteData <= dataIn;
    end
  end
endmodule

// File: rtl/pbyte_cfg_rx_shifter.sv
`timescale 1ns/1ps
module pbyte_cfg_rx_shifter #(
  parameter int   DATA_W     = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReady,
  input  logic              loadNow,
  input  logic [DATA_W-1:0] loadByte,
  output logic              serialOut
);
  localparam logic [DATA_W-1:0] IDLE_WORD = {DATA_W{IDLE_LEVEL}};

  logic [DATA_W-1:0] shiftReg;

  // falling-edge register: output moves half a period after the load
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= IDLE_WORD;
      serialOut <= IDLE_LEVEL;
    end else if (!initReady) begin
      shiftReg  <= IDLE_WORD;
      serialOut <= IDLE_LEVEL;
    end else if (loadNow) begin
      serialOut <= loadByte[DATA_W-1];
      shiftReg  <= {loadByte[DATA_W-2:0], IDLE_LEVEL};
    end else begin
      serialOut <= shiftReg[DATA_W-1];
      shiftReg  <= {shiftReg[DATA_W-2:0], IDLE_LEVEL};
    end
  end
endmodule

// File: rtl/pbyte_cfg_rx.sv
`timescale 1ns/1ps
module pbyte_cfg_rx
  import pbyte_cfg_rx_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter int   LEAD_EDGES = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReady,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ack,
  output logic              serialOut,
  output logic              byteValid,
  output logic [DATA_W-1:0] byteData
);
  rxStrobe_t strobe;

  pbyte_cfg_rx_ctrl #(.DATA_W(DATA_W), .LEAD_EDGES(LEAD_EDGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .initReady(initReady), .strobe(strobe), .ack(ack)
  );

  pbyte_cfg_rx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .byteValid(byteValid), .byteData(byteData)
  );

  pbyte_cfg_rx_shifter #(.DATA_W(DATA_W), .IDLE_LEVEL(IDLE_LEVEL)) u_shift (
    .clk(clk), .rstN(rstN), .initReady(initReady), .loadNow(byteValid),
    .loadByte(byteData), .serialOut(serialOut)
  );
endmodule

// File: rtl/pbyte_cfg_rx_chk.sv
`timescale 1ns/1ps
module pbyte_cfg_rx_chk #(
  parameter int   DATA_W     = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              initReady,
  input logic              ack,
  input logic              serialOut,
  input logic              byteValid,
  input logic [DATA_W-1:0] byteData
);
  logic       seenAck;
  logic [7:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenAck <= 1'b0;
      gapCnt  <= '0;
    end else if (!initReady) begin
      seenAck <= 1'b0;
      gapCnt  <= '0;
    end else if (ack) begin
      seenAck <= 1'b1;
      gapCnt  <= '0;
    end else if (gapCnt != 8'hFF) begin
      gapCnt  <= gapCnt + 1'b1;
    end
  end

  p_ack_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  p_valid_with_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    byteValid == ack);

  p_cadence_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ack && seenAck) |-> (gapCnt == 8'(DATA_W - 1)));

  p_quiet_when_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !initReady |=> (!ack && !byteValid));

  p_msb_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ack && initReady) |-> (serialOut == byteData[DATA_W-1]));

  p_idle_serial_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!initReady && $past(!initReady)) |-> (serialOut == IDLE_LEVEL));
endmodule

bind pbyte_cfg_rx pbyte_cfg_rx_chk #(.DATA_W(DATA_W), .IDLE_LEVEL(IDLE_LEVEL)) u_chk (
  .clk(clk), .rstN(rstN), .initReady(initReady), .ack(ack),
  .serialOut(serialOut), .byteValid(byteValid), .byteData(byteData)
);

// File: tb/pbyte_cfg_rx_tb.sv
`timescale 1ns/1ps
module pbyte_cfg_rx_tb;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h6E};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       initReady = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       ack, serialOut, byteValid;
  logic [7:0] byteData;

  int passCnt = 0;
  int totalCnt = 0;

  always #2.5 clk = ~clk;

  pbyte_cfg_rx u_dut (
    .clk(clk), .rstN(rstN), .initReady(initReady), .dataIn(dataIn),
    .ack(ack), .serialOut(serialOut), .byteValid(byteValid), .byteData(byteData)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
  endtask

  task automatic stepPos();
    @(posedge clk); #1;
  endtask

  task automatic stepNeg();
    @(negedge clk); #1;
  endtask

  initial begin
    #1000000;
    totalCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) stepPos();
    check(ack == 1'b0, "R1 ack", ack, 0);
    check(byteValid == 1'b0, "R1 byteValid", byteValid, 0);
    check(serialOut == 1'b1, "R1 serialOut", serialOut, 1);
    rstN = 1'b1;
    repeat (2) stepPos();
    check(ack == 1'b0, "R8 ack while init low", ack, 0);

    // table walk: stream of NV bytes, garbage between capture edges (R5)
    initReady = 1'b1;
    dataIn    = 8'h5A;
    for (int cyc = 1; cyc <= 8 * NV + 1; cyc++) begin
      bit isCap;
      int k;
      stepPos();
      isCap = (cyc >= 2) && ((cyc - 2) % 8 == 0);
      k = (cyc >= 2) ? (cyc - 2) / 8 : 0;
      check(ack == isCap, (cyc <= 2) ? "R2 ack timing" : "R3 ack cadence", ack, isCap);
      check(byteValid == isCap, "R4 byteValid with ack", byteValid, isCap);
      if (isCap) check(byteData == VEC[k], "R5 captured byte", byteData, VEC[k]);
      if ((cyc + 1 - 2) % 8 == 0 && (cyc - 1) / 8 < NV) dataIn = VEC[(cyc - 1) / 8];
      else dataIn = 8'h5A ^ 8'(cyc * 37);
      stepNeg();
      if (cyc >= 2) begin
        logic expBit;
        expBit = VEC[k][7 - ((cyc - 2) % 8)];
        check(serialOut == expBit, (k == NV - 1) ? "R7 last byte shift" : "R6 serial bit",
              serialOut, expBit);
      end else begin
        check(serialOut == 1'b1, "R6 idle before load", serialOut, 1);
      end
    end

    // abort mid-stream (R8), then restart (R9)
    repeat (4) stepPos();
    initReady = 1'b0;
    stepNeg();
    check(serialOut == 1'b1, "R8 idle after abort", serialOut, 1);
    for (int i = 0; i < 10; i++) begin
      stepPos();
      check(ack == 1'b0 && byteValid == 1'b0, "R8 quiet while low", ack, 0);
    end
    initReady = 1'b1;
    dataIn    = 8'hC3;
    stepPos();
    check(ack == 1'b0, "R9 no capture on first edge", ack, 0);
    stepPos();
    check(ack == 1'b1, "R9 capture on second edge", ack, 1);
    check(byteData == 8'hC3, "R9 restart byte", byteData, 8'hC3);
    stepNeg();
    check(serialOut == 1'b1, "R6 restart msb", serialOut, 1);
    stepPos();
    check(ack == 1'b0, "R4 ack one period", ack, 0);
    stepNeg();
    check(serialOut == 1'b1, "R6 restart bit6", serialOut, 1);
    stepNeg();
    check(serialOut == 1'b0, "R6 restart bit5", serialOut, 0);

    // reset mid-stream returns to R1 state
    rstN = 1'b0;
    #1;
    check(ack == 1'b0 && byteValid == 1'b0, "R1 async reset", ack, 0);
    check(serialOut == 1'b1, "R1 serial reset", serialOut, 1);

    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule